// File: doc/BRIEF.md
# Bridge Configuration Register Block

This block is the type-1 configuration header of a PCI-to-PCI bridge. It takes dword-addressed configuration writes with per-byte enables and configuration reads, and it holds the registers a bridge needs in order to forward traffic. These are the bus numbers, the secondary latency timer, the command word, the I/O, memory and prefetchable base/limit pairs with their upper-address extensions, and the bridge control word. Identity and capability fields are constants that read back through the same port.

Next to the raw register values, the block presents the three forwarding windows as decoded byte addresses (base and inclusive limit), ready for a window decoder. Any write whose enabled bytes land in a window-defining or enable-defining span raises a one-cycle remap strobe, so the decoder can reload its windows. Setting the secondary-bus-reset control bit from 0 to 1 produces a reset pulse of fixed length toward the secondary side.

Top module: `bcfg_bridge_regs`

## Requirements
- R1: When reset is released, the bus-number dword (offset 0x18), the address fields of every base/limit register, both prefetchable upper-32 dwords (0x28, 0x2C), the I/O upper-16 dword (0x30), the command word and bridge control all read zero, and remap and secondary reset are low.
- R2: A write changes only the bytes whose enable is set, and only the writable bits: command bits 0,1,2,6,8 (0x04 low half), all 32 bits at 0x18, 0x28, 0x2C and 0x30, the address nibbles [7:4] and [15:12] at 0x1C, bits [15:4] and [31:20] at 0x20 and 0x24, and bridge control bits [11:0] (0x3C upper half).
- R3: The type nibbles at 0x1C bits [3:0] and [11:8] read 1 (32-bit I/O), the nibbles at 0x24 bits [3:0] and [19:16] read 1 (64-bit prefetchable), and the nibbles at 0x20 read 0. Writes do not change any of them.
- R4: Offset 0x00 reads {device id, vendor id}, offset 0x08 reads class code 0x060400 above the revision byte, and offset 0x0C byte 2 reads header type 0x01 with bit 7 equal to the multi-function parameter. None of these is writable.
- R5: The primary status (0x04 upper half) and secondary status (0x1C upper half) read 0x00A0, which flags 66 MHz capable and fast back-to-back capable, and writes do not change them.
- R6: Read data appears on the port one cycle after the read strobe and holds until the next read. Dword offsets 0x10, 0x14, 0x34, 0x38 and every offset at 0x40 or above read zero.
- R7: The cycle after a write, remap is high exactly when some enabled byte lies in 0x04–0x05, 0x1C–0x1D, 0x20–0x33 or 0x3E–0x3F. Writes that touch only status bytes, bus numbers, 0x34–0x3D, or that have no byte enabled, leave remap low.
- R8: A write that takes bridge control bit 6 from 0 to 1 drives secondary reset high for exactly 16 cycles, starting the cycle after the write. Writing 1 while the bit is already 1 starts no pulse.
- R9: The decoded windows are: I/O base {io-upper[15:0], nibble, 12'h000} with limit low 12 bits all ones; memory base {field[15:4], 20'h0} with limit low 20 bits all ones; prefetchable base and limit are 64-bit, with the upper dword above and the low 20 bits cleared (base) or all ones (limit).
- R10: With the closed-at-reset variant, every base address field resets to all ones and every limit field to zero, so each decoded limit lies below its base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr_i | input | ADDR_W | Dword index of the configuration access |
| cfg_wdata_i | input | 32 | Write data |
| cfg_be_i | input | 4 | Byte enables, bit n for byte lane n |
| cfg_wr_i | input | 1 | Write strobe |
| cfg_rd_i | input | 1 | Read strobe |
| cfg_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| pri_bus_o | output | 8 | Primary bus number |
| sec_bus_o | output | 8 | Secondary bus number |
| sub_bus_o | output | 8 | Subordinate bus number |
| sec_lat_o | output | 8 | Secondary latency timer |
| cmd_o | output | 16 | Command word |
| bctl_o | output | 16 | Bridge control word |
| io_base_o | output | 32 | Decoded I/O window base |
| io_limit_o | output | 32 | Decoded I/O window limit (inclusive) |
| mem_base_o | output | 32 | Decoded memory window base |
| mem_limit_o | output | 32 | Decoded memory window limit (inclusive) |
| pref_base_o | output | 64 | Decoded prefetchable window base |
| pref_limit_o | output | 64 | Decoded prefetchable window limit (inclusive) |
| remap_o | output | 1 | One-cycle strobe after a window-affecting write |
| sec_rst_o | output | 1 | Secondary bus reset pulse |

## Verification
The bench aims at the edges of the remap spans. Status-only writes at 0x06 and 0x1E, the byte at 0x33 next to the unaffected 0x34, the interrupt bytes at 0x3C–0x3D next to bridge control, and a write with no enables all probe them. A design with loose span edges would raise remap for these writes, or miss it. The read-only type and status nibbles are written with all ones and read back; a design that stored them would report changed types or capabilities. The reset pulse is started, retriggered by writing 1 over 1, and measured in length. A level-sensitive design would pulse again, and a counter off by one would show 15 or 17 cycles. Randomized writes with random byte enables, compared against a bench model of the masks, catch lanes that are swapped or ignored.

// File: rtl/bcfg_pkg.sv
// Shared constants, types and helpers for the bridge configuration block.
// Assumes a 64-byte type-1 header made of 16 dwords; offsets here are
// fixed by the configuration-space layout that software decodes.
package bcfg_pkg;

    localparam int NDW = 16;

    // Dword indices of the implemented registers
    localparam int DW_ID   = 0;
    localparam int DW_CMD  = 1;
    localparam int DW_CLS  = 2;
    localparam int DW_HDR  = 3;
    localparam int DW_BUS  = 6;
    localparam int DW_IOBL = 7;
    localparam int DW_MEM  = 8;
    localparam int DW_PREF = 9;
    localparam int DW_PBU  = 10;
    localparam int DW_PLU  = 11;
    localparam int DW_IOU  = 12;
    localparam int DW_BCTL = 15;

    // Bit of the dword at DW_BCTL that requests a secondary bus reset
    localparam int SBR_BIT = 16 + 6;

    localparam logic [15:0] STATUS_CAPS  = 16'h00A0;
    localparam logic [23:0] CLASS_BRIDGE = 24'h060400;
    localparam logic [6:0]  HDR_BRIDGE   = 7'h01;

    // Decoded forwarding windows handed to the decoder
    typedef struct packed {
        logic [31:0] io_base;
        logic [31:0] io_limit;
        logic [31:0] mem_base;
        logic [31:0] mem_limit;
        logic [63:0] pref_base;
        logic [63:0] pref_limit;
    } win_t;

    // Expand byte enables to a 32-bit bit mask
    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    // True when a byte offset within the header belongs to a window span
    function automatic logic in_remap_span(input logic [5:0] a);
        return (a >= 6'h04 && a <= 6'h05) ||
               (a >= 6'h1C && a <= 6'h1D) ||
               (a >= 6'h20 && a <= 6'h33) ||
               (a >= 6'h3E && a <= 6'h3F);
    endfunction

endpackage

// File: rtl/bcfg_regfile.sv
// Dword register array of the bridge header.
// Each dword has a writable mask, a read-only overlay and a reset value,
// all derived from parameters. Dwords with no writable bit hold no
// flops. Assumes idx_i is only meaningful when sel_i is high.
module bcfg_regfile
    import bcfg_pkg::*;
#(
    parameter int          IDX_W           = 4,
    parameter logic [15:0] VENDOR_ID       = 16'hA5A5,
    parameter logic [15:0] DEVICE_ID       = 16'h5A01,
    parameter logic [7:0]  REV_ID          = 8'h02,
    parameter bit          MULTI_FN        = 1'b0,
    parameter bit          IO32            = 1'b1,
    parameter bit          PREF64          = 1'b1,
    parameter logic [15:0] CMD_WMASK       = 16'h0147,
    parameter logic [15:0] BCTL_WMASK      = 16'h0FFF,
    parameter bit          CLOSED_AT_RESET = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic                  sel_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [31:0]           wdata_i,
    input  logic [3:0]            be_i,
    output logic [NDW-1:0][31:0]  val_o
);

    localparam logic [3:0] IO_T = IO32   ? 4'h1 : 4'h0;
    localparam logic [3:0] PF_T = PREF64 ? 4'h1 : 4'h0;

    // Writable bits per dword
    function automatic logic [31:0] wmask_of(input int i);
        case (i)
            DW_CMD:          return {16'h0000, CMD_WMASK};
            DW_BUS:          return 32'hFFFF_FFFF;
            DW_IOBL:         return 32'h0000_F0F0;
            DW_MEM, DW_PREF: return 32'hFFF0_FFF0;
            DW_PBU, DW_PLU:  return PREF64 ? 32'hFFFF_FFFF : 32'h0;
            DW_IOU:          return IO32 ? 32'hFFFF_FFFF : 32'h0;
            DW_BCTL:         return {BCTL_WMASK, 16'h0000};
            default:         return 32'h0;
        endcase
    endfunction

    // Constant bits overlaid on each dword
    function automatic logic [31:0] ro_of(input int i);
        case (i)
            DW_ID:   return {DEVICE_ID, VENDOR_ID};
            DW_CMD:  return {STATUS_CAPS, 16'h0000};
            DW_CLS:  return {CLASS_BRIDGE, REV_ID};
            DW_HDR:  return {8'h00, MULTI_FN, HDR_BRIDGE, 16'h0000};
            DW_IOBL: return {STATUS_CAPS, 4'h0, IO_T, 4'h0, IO_T};
            DW_PREF: return {12'h000, PF_T, 12'h000, PF_T};
            default: return 32'h0;
        endcase
    endfunction

    // Reset contents of the writable bits
    function automatic logic [31:0] rst_of(input int i);
        if (!CLOSED_AT_RESET) return 32'h0;
        case (i)
            DW_IOBL:         return 32'h0000_00F0;
            DW_MEM, DW_PREF: return 32'h0000_FFF0;
            default:         return 32'h0;
        endcase
    endfunction

    logic [31:0] be_bits;
    assign be_bits = lane_mask(be_i);

    for (genvar i = 0; i < NDW; i++) begin : g_dw
        localparam logic [31:0] WM = wmask_of(i);
        localparam logic [31:0] RO = ro_of(i);
        localparam logic [31:0] RV = rst_of(i);
        if (WM == 32'h0) begin : g_const
            assign val_o[i] = RO;
        end else begin : g_store
            logic [31:0] q;
            logic [31:0] m;
            assign m = be_bits & WM;
            // Hold the writable bits, merging enabled bytes on a hit
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= RV;
                else if (wr_i && sel_i && idx_i == IDX_W'(i))
                    q <= (q & ~m) | (wdata_i & m);
            end
            assign val_o[i] = (q & WM) | RO;
        end
    end

endmodule

// File: rtl/bcfg_remap_detect.sv
// Flags writes that touch the window-defining byte spans.
// Each enabled byte lane is tested on its own byte offset; the result
// is registered so remap_o is a one-cycle strobe after the write.
// Assumes ADDR_W >= 5 so the header fits in the address space.
module bcfg_remap_detect
    import bcfg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        be_i,
    output logic              remap_o
);

    localparam int BA_W = ADDR_W + 2;

    logic [3:0] lane_hit;

    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic [BA_W-1:0] ba;
        assign ba = {addr_i, 2'(l)};
        assign lane_hit[l] = be_i[l] && (ba[BA_W-1:6] == '0) &&
                             in_remap_span(ba[5:0]);
    end

    // Register the span hit of the current write
    always_ff @(posedge clk) begin
        if (!rst_n) remap_o <= 1'b0;
        else        remap_o <= wr_i && (lane_hit != 4'b0000);
    end

endmodule

// File: rtl/bcfg_sec_reset.sv
// Secondary bus reset pulse generator.
// A start request loads a down-counter; the output is high while it is
// non-zero, giving exactly CYCLES high cycles after the request.
// A new start while counting reloads the full length.
module bcfg_sec_reset #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on a start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= CNT_W'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);

endmodule

// File: rtl/bcfg_window_decode.sv
// Turns base/limit register dwords into byte-address windows.
// Base addresses clear the low granule bits and limits fill them with
// ones. Upper extensions are used only when the matching parameter
// selects 32-bit I/O or 64-bit prefetchable addressing.
module bcfg_window_decode
    import bcfg_pkg::*;
#(
    parameter bit IO32   = 1'b1,
    parameter bit PREF64 = 1'b1
) (
    input  logic [31:0] iobl_i,
    input  logic [31:0] iou_i,
    input  logic [31:0] mem_i,
    input  logic [31:0] pref_i,
    input  logic [31:0] pbu_i,
    input  logic [31:0] plu_i,
    output win_t        win_o
);

    logic [15:0] io_up_b, io_up_l;
    logic [31:0] pf_up_b, pf_up_l;

    if (IO32) begin : g_io32
        assign io_up_b = iou_i[15:0];
        assign io_up_l = iou_i[31:16];
    end else begin : g_io16
        assign io_up_b = 16'h0;
        assign io_up_l = 16'h0;
    end

    if (PREF64) begin : g_pf64
        assign pf_up_b = pbu_i;
        assign pf_up_l = plu_i;
    end else begin : g_pf32
        assign pf_up_b = 32'h0;
        assign pf_up_l = 32'h0;
    end

    // Assemble the window addresses from the register fields
    always_comb begin
        win_o.io_base    = {io_up_b, iobl_i[7:4],   12'h000};
        win_o.io_limit   = {io_up_l, iobl_i[15:12], 12'hFFF};
        win_o.mem_base   = {mem_i[15:4],  20'h00000};
        win_o.mem_limit  = {mem_i[31:20], 20'hFFFFF};
        win_o.pref_base  = {pf_up_b, pref_i[15:4],  20'h00000};
        win_o.pref_limit = {pf_up_l, pref_i[31:20], 20'hFFFFF};
    end

endmodule

// File: rtl/bcfg_bridge_regs.sv
// Bridge configuration register block (top).
// Accepts byte-enabled dword writes and one-cycle-latency reads of the
// type-1 header, exposes register values and decoded windows, strobes
// remap after window-affecting writes and pulses the secondary reset on
// a 0-to-1 write of the bus-reset control bit. Assumes ADDR_W >= 5 and
// that BCTL_WMASK keeps the bus-reset bit writable for the pulse to occur.
module bcfg_bridge_regs
    import bcfg_pkg::*;
#(
    parameter int          ADDR_W          = 6,
    parameter logic [15:0] VENDOR_ID       = 16'hA5A5,
    parameter logic [15:0] DEVICE_ID       = 16'h5A01,
    parameter logic [7:0]  REV_ID          = 8'h02,
    parameter bit          MULTI_FN        = 1'b0,
    parameter bit          IO32            = 1'b1,
    parameter bit          PREF64          = 1'b1,
    parameter logic [15:0] CMD_WMASK       = 16'h0147,
    parameter logic [15:0] BCTL_WMASK      = 16'h0FFF,
    parameter bit          CLOSED_AT_RESET = 1'b0,
    parameter int          SEC_RST_CYCLES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [31:0]       cfg_wdata_i,
    input  logic [3:0]        cfg_be_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_rd_i,
    output logic [31:0]       cfg_rdata_o,
    output logic [7:0]        pri_bus_o,
    output logic [7:0]        sec_bus_o,
    output logic [7:0]        sub_bus_o,
    output logic [7:0]        sec_lat_o,
    output logic [15:0]       cmd_o,
    output logic [15:0]       bctl_o,
    output logic [31:0]       io_base_o,
    output logic [31:0]       io_limit_o,
    output logic [31:0]       mem_base_o,
    output logic [31:0]       mem_limit_o,
    output logic [63:0]       pref_base_o,
    output logic [63:0]       pref_limit_o,
    output logic              remap_o,
    output logic              sec_rst_o
);

    localparam int IDX_W = $clog2(NDW);

    logic [NDW-1:0][31:0] val;
    logic [IDX_W-1:0]     idx;
    logic                 in_hdr;
    logic                 sbr_start;
    win_t                 win;

    assign idx    = cfg_addr_i[IDX_W-1:0];
    assign in_hdr = (cfg_addr_i[ADDR_W-1:IDX_W] == '0);

    bcfg_regfile #(
        .IDX_W(IDX_W), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
        .REV_ID(REV_ID), .MULTI_FN(MULTI_FN), .IO32(IO32), .PREF64(PREF64),
        .CMD_WMASK(CMD_WMASK), .BCTL_WMASK(BCTL_WMASK),
        .CLOSED_AT_RESET(CLOSED_AT_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .sel_i(in_hdr),
        .idx_i(idx), .wdata_i(cfg_wdata_i), .be_i(cfg_be_i), .val_o(val)
    );

    bcfg_remap_detect #(.ADDR_W(ADDR_W)) u_remap (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .addr_i(cfg_addr_i),
        .be_i(cfg_be_i), .remap_o(remap_o)
    );

    // Rising request: writable bus-reset bit written 1 while currently 0
    assign sbr_start = cfg_wr_i && in_hdr && (idx == IDX_W'(DW_BCTL)) &&
                       cfg_be_i[SBR_BIT/8] && cfg_wdata_i[SBR_BIT] &&
                       BCTL_WMASK[SBR_BIT-16] && !val[DW_BCTL][SBR_BIT];

    bcfg_sec_reset #(.CYCLES(SEC_RST_CYCLES)) u_sbr (
        .clk(clk), .rst_n(rst_n), .start_i(sbr_start), .active_o(sec_rst_o)
    );

    bcfg_window_decode #(.IO32(IO32), .PREF64(PREF64)) u_win (
        .iobl_i(val[DW_IOBL]), .iou_i(val[DW_IOU]), .mem_i(val[DW_MEM]),
        .pref_i(val[DW_PREF]), .pbu_i(val[DW_PBU]), .plu_i(val[DW_PLU]),
        .win_o(win)
    );

    // Capture read data one cycle after the strobe; zero outside the header
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_rdata_o <= 32'h0;
        else if (cfg_rd_i)
            cfg_rdata_o <= in_hdr ? val[idx] : 32'h0;
    end

    assign pri_bus_o    = val[DW_BUS][7:0];
    assign sec_bus_o    = val[DW_BUS][15:8];
    assign sub_bus_o    = val[DW_BUS][23:16];
    assign sec_lat_o    = val[DW_BUS][31:24];
    assign cmd_o        = val[DW_CMD][15:0];
    assign bctl_o       = val[DW_BCTL][31:16];
    assign io_base_o    = win.io_base;
    assign io_limit_o   = win.io_limit;
    assign mem_base_o   = win.mem_base;
    assign mem_limit_o  = win.mem_limit;
    assign pref_base_o  = win.pref_base;
    assign pref_limit_o = win.pref_limit;

endmodule

// File: rtl/bcfg_bridge_regs_chk.sv
// Property checker for the bridge configuration block, bound to the top.
// Tracks the length of each secondary reset pulse with a local counter.
module bcfg_bridge_regs_chk #(
    parameter int ADDR_W         = 6,
    parameter int SEC_RST_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_addr_i,
    input logic              cfg_wr_i,
    input logic              cfg_rd_i,
    input logic [31:0]       cfg_rdata_o,
    input logic [7:0]        pri_bus_o,
    input logic [7:0]        sec_bus_o,
    input logic [7:0]        sub_bus_o,
    input logic [7:0]        sec_lat_o,
    input logic [15:0]       bctl_o,
    input logic              remap_o,
    input logic              sec_rst_o
);

    localparam int RUN_W = $clog2(SEC_RST_CYCLES + 2) + 1;

    logic [RUN_W-1:0] run_q;

    // Count consecutive cycles with the secondary reset high
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (sec_rst_o) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    assert_rst_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pri_bus_o == 8'h0 && sec_bus_o == 8'h0 &&
                           sub_bus_o == 8'h0 && sec_lat_o == 8'h0 &&
                           bctl_o == 16'h0 && !remap_o && !sec_rst_o));

    assert_remap_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        remap_o |-> $past(cfg_wr_i));

    assert_sbr_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_rst_o) |-> ($past(cfg_wr_i) && bctl_o[6]));

    assert_sbr_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sec_rst_o) |-> (run_q >= RUN_W'(SEC_RST_CYCLES)));

    assert_unimpl_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_rd_i) && ($past(cfg_addr_i) >= ADDR_W'(16))) |-> cfg_rdata_o == 32'h0);

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_rd_i) |-> $stable(cfg_rdata_o));

endmodule

bind bcfg_bridge_regs bcfg_bridge_regs_chk #(
    .ADDR_W(ADDR_W), .SEC_RST_CYCLES(SEC_RST_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_addr_i(cfg_addr_i), .cfg_wr_i(cfg_wr_i),
    .cfg_rd_i(cfg_rd_i), .cfg_rdata_o(cfg_rdata_o), .pri_bus_o(pri_bus_o),
    .sec_bus_o(sec_bus_o), .sub_bus_o(sub_bus_o), .sec_lat_o(sec_lat_o),
    .bctl_o(bctl_o), .remap_o(remap_o), .sec_rst_o(sec_rst_o)
);

// File: tb/sim_bcfg_bridge_regs.sv
`timescale 1ns/1ps
module sim_bcfg_bridge_regs;

    localparam int NSBR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic        wr = 1'b0, rd = 1'b0;

    logic [31:0] rdata, rdata1;
    logic [7:0]  pri, sec, sub, lat, pri1, sec1, sub1, lat1;
    logic [15:0] cmd, bctl, cmd1, bctl1;
    logic [31:0] iob, iol, mb, ml, iob1, iol1, mb1, ml1;
    logic [63:0] pb, pl, pb1, pl1;
    logic        remap, sbr, remap1, sbr1;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] mdl [16];

    always #2.5 clk = ~clk;

    bcfg_bridge_regs u0 (
        .clk(clk), .rst_n(rst_n), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .cfg_be_i(be), .cfg_wr_i(wr), .cfg_rd_i(rd), .cfg_rdata_o(rdata),
        .pri_bus_o(pri), .sec_bus_o(sec), .sub_bus_o(sub), .sec_lat_o(lat),
        .cmd_o(cmd), .bctl_o(bctl), .io_base_o(iob), .io_limit_o(iol),
        .mem_base_o(mb), .mem_limit_o(ml), .pref_base_o(pb), .pref_limit_o(pl),
        .remap_o(remap), .sec_rst_o(sbr)
    );

    bcfg_bridge_regs #(.CLOSED_AT_RESET(1'b1), .MULTI_FN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .cfg_be_i(be), .cfg_wr_i(wr), .cfg_rd_i(rd), .cfg_rdata_o(rdata1),
        .pri_bus_o(pri1), .sec_bus_o(sec1), .sub_bus_o(sub1), .sec_lat_o(lat1),
        .cmd_o(cmd1), .bctl_o(bctl1), .io_base_o(iob1), .io_limit_o(iol1),
        .mem_base_o(mb1), .mem_limit_o(ml1), .pref_base_o(pb1), .pref_limit_o(pl1),
        .remap_o(remap1), .sec_rst_o(sbr1)
    );

    // Writable bits per dword, from R2
    function automatic logic [31:0] wm(input int i);
        case (i)
            1:      return 32'h0000_0147;
            6:      return 32'hFFFF_FFFF;
            7:      return 32'h0000_F0F0;
            8, 9:   return 32'hFFF0_FFF0;
            10, 11: return 32'hFFFF_FFFF;
            12:     return 32'hFFFF_FFFF;
            15:     return 32'h0FFF_0000;
            default: return 32'h0;
        endcase
    endfunction

    // Constant read bits per dword, from R3, R4, R5
    function automatic logic [31:0] ro(input int i, input bit mf);
        case (i)
            0: return 32'h5A01_A5A5;
            1: return 32'h00A0_0000;
            2: return 32'h0604_0002;
            3: return {8'h00, mf, 7'h01, 16'h0000};
            7: return 32'h00A0_0101;
            9: return 32'h0001_0001;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input int a);
        if (a >= 16) return 32'h0;
        return (mdl[a] & wm(a)) | ro(a, 1'b0);
    endfunction

    // Remap expectation from the byte spans of R7
    function automatic bit exp_remap(input int a, input logic [3:0] b);
        bit h = 0;
        for (int l = 0; l < 4; l++) begin
            int ba = a * 4 + l;
            if (b[l] && ((ba >= 'h04 && ba <= 'h05) || (ba >= 'h1C && ba <= 'h1D) ||
                         (ba >= 'h20 && ba <= 'h33) || (ba >= 'h3E && ba <= 'h3F)))
                h = 1;
        end
        return h;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    // Write one dword, then sample remap in the following cycle
    task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] b,
                            input bit chk_remap);
        logic [31:0] m;
        @(negedge clk);
        addr = 6'(a); wdata = d; be = b; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; be = 4'h0;
        if (a < 16) begin
            m = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}} & wm(a);
            mdl[a] = (mdl[a] & ~m) | (d & m);
        end
        if (chk_remap) check("R7 remap", 64'(remap), 64'(exp_remap(a, b)));
    endtask

    task automatic do_read(input int a, input string req);
        @(negedge clk);
        addr = 6'(a); rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check(req, 64'(rdata), 64'(exp_rd(a)));
    endtask

    task automatic check_windows();
        check("R9 io_base",   64'(iob), 64'({mdl[12][15:0], mdl[7][7:4], 12'h000}));
        check("R9 io_limit",  64'(iol), 64'({mdl[12][31:16], mdl[7][15:12], 12'hFFF}));
        check("R9 mem_base",  64'(mb),  64'({mdl[8][15:4], 20'h0}));
        check("R9 mem_limit", 64'(ml),  64'({mdl[8][31:20], 20'hFFFFF}));
        check("R9 pref_base", pb, {mdl[10], mdl[9][15:4], 20'h0});
        check("R9 pref_limit", pl, {mdl[11], mdl[9][31:20], 20'hFFFFF});
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        int hi;
        int seed;
        seed = $urandom(32'd20241);
        for (int i = 0; i < 16; i++) mdl[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports and through reads
        check("R1 bus numbers", {32'h0, pri, sec, sub, lat}, 64'h0);
        check("R1 cmd/bctl", {32'h0, cmd, bctl}, 64'h0);
        check("R1 remap/sbr", {62'h0, remap, sbr}, 64'h0);
        // R10: closed variant opens no window
        check("R10 closed io", {iob1, iol1}, {32'h0000_F000, 32'h0000_0FFF});
        check("R10 closed mem", {mb1, ml1}, {32'hFFF0_0000, 32'h000F_FFFF});
        check("R10 closed pref", {pb1[31:0], pl1[31:0]}, {32'hFFF0_0000, 32'h000F_FFFF});
        do_read(3, "R4 header");
        check("R4 multifn header", 64'(rdata1), 64'({8'h00, 8'h81, 16'h0}));
        for (int a = 0; a < 16; a++) do_read(a, "R1 R4 R5 reset read");
        check_windows();

        // R6: unimplemented offsets and read hold
        do_read(4, "R6 unimpl 0x10");
        do_read(13, "R6 unimpl 0x34");
        do_read(47, "R6 beyond header");
        do_read(0, "R6 id read");
        repeat (3) @(negedge clk);
        check("R6 hold", 64'(rdata), 64'(exp_rd(0)));

        // R3, R5: read-only nibbles and status ignore writes
        do_write(7, 32'hFFFF_FFFF, 4'hF, 1);
        do_read(7, "R3 R5 io base/limit ro");
        do_write(9, 32'hFFFF_FFFF, 4'hF, 1);
        do_read(9, "R3 pref ro nibbles");
        do_write(8, 32'hFFFF_FFFF, 4'hF, 1);
        do_read(8, "R3 mem nibbles zero");
        do_write(1, 32'hFFFF_FFFF, 4'hC, 1);
        do_read(1, "R5 primary status ro");
        do_write(0, 32'h0, 4'hF, 1);
        do_read(0, "R4 id ro");

        // R7: span edges
        do_write(1, 32'h0000_0001, 4'h1, 1);
        do_write(7, 32'h1234_0000, 4'h8, 1);
        do_write(7, 32'h0000_5000, 4'h2, 1);
        do_write(12, 32'hAB00_0000, 4'h8, 1);
        do_write(13, 32'hFFFF_FFFF, 4'hF, 1);
        do_write(15, 32'h0000_FFFF, 4'h3, 1);
        do_write(6, 32'h0302_0100, 4'hF, 1);
        do_write(8, 32'hFFFF_FFFF, 4'h0, 1);
        do_write(15, 32'h0008_0000, 4'h4, 1);
        do_read(6, "R2 bus dword");
        check("R2 bus ports", {32'h0, pri, sec, sub, lat}, 64'h0000_0000_0001_0203);
        check("R2 cmd port", 64'(cmd), 64'(mdl[1][15:0]));

        // R8: rising edge pulse length and no pulse on 1-over-1
        do_write(15, 32'h0040_0000, 4'h4, 0);
        hi = 0;
        for (int c = 0; c < NSBR + 4; c++) begin
            if (sbr) hi++;
            @(negedge clk);
        end
        check("R8 pulse length", 64'(hi), 64'(NSBR));
        do_write(15, 32'h0040_0000, 4'h4, 0);
        check("R8 no pulse on 1 over 1", 64'(sbr), 64'h0);
        do_write(15, 32'h0000_0000, 4'h4, 0);
        check("R8 no pulse on clear", 64'(sbr), 64'h0);
        do_write(15, 32'h0040_0000, 4'h4, 0);
        check("R8 pulse again", 64'(sbr), 64'h1);
        do_write(15, 32'h0000_0000, 4'h4, 0);
        repeat (NSBR + 2) @(negedge clk);
        check("R8 pulse ended", 64'(sbr), 64'h0);

        // R2, R7, R9: random byte-enabled traffic
        for (int n = 0; n < 400; n++) begin
            int a;
            logic [31:0] d;
            logic [3:0] b;
            a = int'($urandom % 20);
            d = $urandom;
            b = 4'($urandom);
            if (a == 15) d[22] = 1'b0;
            do_write(a, d, b, 1);
            do_read(a, "R2 random readback");
            if (n % 16 == 0) check_windows();
        end
        check_windows();

        done = 1;
        report();
    end

endmodule